// File: doc/BRIEF.md
# Endpoint Interrupt Flag Controller

This block keeps the interrupt flags of one endpoint of a device-side serial bus controller and merges them into a single interrupt line. There are nine flags. Each has a fixed bit position and its own enable bit. Each flag is set by a one-cycle event pulse from the transfer logic. Several flags first have to pass a qualifier: the endpoint's direction, its isochronous type, its DMA end and auto-switch settings, or a pending stall request.

Software sees the block through a narrow write port with four addresses. Address 0 is a write-one-to-clear register for the flags. Address 1 is the enable mask. Address 2 raises the stall request and address 3 drops it. The flags, the enables and the stall request are visible on output ports. The high-bandwidth flags can be removed at elaboration. The interrupt line can be taken combinationally or through a register.

Top module: `ep_irq_ctrl`

## Requirements
- R1: After reset, all flags, all enables and the stall request are 0, and `ep_irq` is low.
- R2: Flag bits are laid out as follows: 0 short packet, 1 stall sent, 2 CRC error, 3 overflow, 4 NAK on IN, 5 NAK on OUT, 6 high-bandwidth flush, 7 high-bandwidth IN underflow, 8 underflow. A qualified pulse on `ev_pulse[i]` sets `flags[i]` at the next clock edge, and the flag then holds.
- R3: A write to address 0 clears every flag whose `wr_data` bit is 1. Flags whose data bit is 0 are left unchanged.
- R4: A write to address 1 loads all nine enable bits from `wr_data`. With the default `IRQ_REG`=0, `ep_irq` is high in the same cycle as any flag that has its enable bit set, and low otherwise.
- R5: On an OUT endpoint (`ep_dir_in`=0), the short-packet event sets bit 0 directly. On an IN endpoint, it sets bit 0 only when `cfg_dmaend_en` and `cfg_autosw` are both 1.
- R6: The stall-sent event sets bit 1 only while `stall_req` is 1.
- R7: A write to address 2 with `wr_data[0]`=1 sets `stall_req`. A write to address 3 with `wr_data[0]`=1 clears it. In both cases a data bit 0 of 0 leaves it unchanged.
- R8: The CRC-error and underflow events set bits 2 and 8 only while `ep_isoch` is 1.
- R9: With `HB_SUPPORT`=1, the two high-bandwidth events set bits 6 and 7 only when `ep_isoch` and `ep_dir_in` are both 1.
- R10: When a qualified event and a clear write hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 clear, 1 enable, 2 stall set, 3 stall clear) |
| wr_data | input | 9 | Write data |
| ev_pulse | input | 9 | Raw event pulses, one per flag bit |
| ep_dir_in | input | 1 | Endpoint is IN (1) or OUT (0) |
| ep_isoch | input | 1 | Endpoint is isochronous |
| cfg_dmaend_en | input | 1 | DMA end output enable control |
| cfg_autosw | input | 1 | Automatic bank switch control |
| flags | output | 9 | Flag state |
| enables | output | 9 | Enable mask |
| stall_req | output | 1 | Stall request state |
| ep_irq | output | 1 | Endpoint interrupt |

## Verification
Two functions can land on the same flag in one clock: a qualified hardware event that sets it, and a software clear write that wipes it. The bench pulses an event in exactly the cycle in which it writes a clear mask to address 0. That mask covers both the raced bit and a second bit that is already set. The test passes only if the raced bit stays set while the other bit is cleared, which shows that the clear was not simply lost.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
   localparam int NFLAG = 9;

   localparam int B_SHORT   = 0;
   localparam int B_STALL   = 1;
   localparam int B_CRC     = 2;
   localparam int B_OVERF   = 3;
   localparam int B_NAKIN   = 4;
   localparam int B_NAKOUT  = 5;
   localparam int B_HBFLUSH = 6;
   localparam int B_HBUNDER = 7;
   localparam int B_UNDERF  = 8;

   localparam int WA_CLR       = 0;
   localparam int WA_EN        = 1;
   localparam int WA_STALL_SET = 2;
   localparam int WA_STALL_CLR = 3;
endpackage

// File: rtl/ep_irq_qual.sv
module ep_irq_qual #(
   parameter int NF         = 9,
   parameter int HB_SUPPORT = 1
) (
   input  logic [NF-1:0] ev_i,
   input  logic          dir_in_i,
   input  logic          isoch_i,
   input  logic          dmaend_i,
   input  logic          autosw_i,
   input  logic          stall_req_i,
   output logic [NF-1:0] set_o
);
   import ep_irq_pkg::*;

   logic hb_ok;

   generate
      if (HB_SUPPORT != 0) begin : g_hb
         assign hb_ok = isoch_i & dir_in_i;
      end else begin : g_nohb
         assign hb_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      set_o            = ev_i;
      set_o[B_SHORT]   = ev_i[B_SHORT] & (~dir_in_i | (dmaend_i & autosw_i));
      set_o[B_STALL]   = ev_i[B_STALL] & stall_req_i;
      set_o[B_CRC]     = ev_i[B_CRC] & isoch_i;
      set_o[B_UNDERF]  = ev_i[B_UNDERF] & isoch_i;
      set_o[B_HBFLUSH] = ev_i[B_HBFLUSH] & hb_ok;
      set_o[B_HBUNDER] = ev_i[B_HBUNDER] & hb_ok;
   end
endmodule

// File: rtl/ep_irq_flagbit.sv
module ep_irq_flagbit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic en_wr_i,
   input  logic en_val_i,
   output logic flag_o,
   output logic en_o,
   output logic hit_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         en_o   <= 1'b0;
      end else begin
         if (set_i)      flag_o <= 1'b1;
         else if (clr_i) flag_o <= 1'b0;
         if (en_wr_i)    en_o   <= en_val_i;
      end
   end

   assign hit_o = flag_o & en_o;
endmodule

// File: rtl/ep_irq_stallreq.sv
module ep_irq_stallreq (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/ep_irq_ctrl.sv
module ep_irq_ctrl #(
   parameter int ADDR_W     = 2,
   parameter int HB_SUPPORT = 1,
   parameter int IRQ_REG    = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [ep_irq_pkg::NFLAG-1:0]  wr_data,
   input  logic [ep_irq_pkg::NFLAG-1:0]  ev_pulse,
   input  logic                          ep_dir_in,
   input  logic                          ep_isoch,
   input  logic                          cfg_dmaend_en,
   input  logic                          cfg_autosw,
   output logic [ep_irq_pkg::NFLAG-1:0]  flags,
   output logic [ep_irq_pkg::NFLAG-1:0]  enables,
   output logic                          stall_req,
   output logic                          ep_irq
);
   import ep_irq_pkg::*;

   localparam int NF = NFLAG;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ep_irq_ctrl: ADDR_W must be at least 2");
      end
      if (HB_SUPPORT < 0 || HB_SUPPORT > 1) begin : g_bad_hb
         $error("ep_irq_ctrl: HB_SUPPORT must be 0 or 1");
      end
      if (IRQ_REG < 0 || IRQ_REG > 1) begin : g_bad_irq
         $error("ep_irq_ctrl: IRQ_REG must be 0 or 1");
      end
   endgenerate

   logic          wr_clr, wr_enr, wr_sset, wr_sclr;
   logic [NF-1:0] qual_set;
   logic [NF-1:0] hit;

   assign wr_clr  = wr_en && (wr_addr == ADDR_W'(WA_CLR));
   assign wr_enr  = wr_en && (wr_addr == ADDR_W'(WA_EN));
   assign wr_sset = wr_en && (wr_addr == ADDR_W'(WA_STALL_SET)) && wr_data[0];
   assign wr_sclr = wr_en && (wr_addr == ADDR_W'(WA_STALL_CLR)) && wr_data[0];

   ep_irq_stallreq u_stall (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (wr_sset),
      .clr_i (wr_sclr),
      .q_o   (stall_req)
   );

   ep_irq_qual #(.NF(NF), .HB_SUPPORT(HB_SUPPORT)) u_qual (
      .ev_i        (ev_pulse),
      .dir_in_i    (ep_dir_in),
      .isoch_i     (ep_isoch),
      .dmaend_i    (cfg_dmaend_en),
      .autosw_i    (cfg_autosw),
      .stall_req_i (stall_req),
      .set_o       (qual_set)
   );

   generate
      for (genvar i = 0; i < NF; i++) begin : g_flag
         ep_irq_flagbit u_bit (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (qual_set[i]),
            .clr_i    (wr_clr & wr_data[i]),
            .en_wr_i  (wr_enr),
            .en_val_i (wr_data[i]),
            .flag_o   (flags[i]),
            .en_o     (enables[i]),
            .hit_o    (hit[i])
         );
      end

      if (IRQ_REG != 0) begin : g_irq_reg
         always_ff @(posedge clk) begin
            if (!rst_n) ep_irq <= 1'b0;
            else        ep_irq <= |hit;
         end
      end else begin : g_irq_comb
         assign ep_irq = |hit;
      end
   endgenerate
endmodule

// File: rtl/ep_irq_chk.sv
module ep_irq_chk #(
   parameter int ADDR_W  = 2,
   parameter int NF      = 9,
   parameter int IRQ_REG = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [NF-1:0]     wr_data,
   input logic              ep_isoch,
   input logic              stall_req,
   input logic [NF-1:0]     flags,
   input logic [NF-1:0]     enables,
   input logic              ep_irq,
   input logic [NF-1:0]     qual_set
);
   logic [NF-1:0] clr_vec;
   assign clr_vec = (wr_en && wr_addr == ADDR_W'(0)) ? wr_data : '0;

   assert_reset_clean_R1: assert property (@(posedge clk)
      !rst_n |=> (flags == '0 && enables == '0 && !stall_req));

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (qual_set != '0) |=> ((flags & $past(qual_set)) == $past(qual_set)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(flags) & ~$past(clr_vec) & ~flags) == '0));

   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_vec & ~qual_set) != '0) |=> ((flags & $past(clr_vec & ~qual_set)) == '0));

   assert_stall_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[1]) |-> $past(stall_req));

   assert_iso_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flags[8]) || $rose(flags[2])) |-> $past(ep_isoch));

   generate
      if (IRQ_REG == 0) begin : g_comb
         assert_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ((flags & enables) != '0) |-> ep_irq);
         assert_irq_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ((flags & enables) == '0) |-> !ep_irq);
      end
   endgenerate
endmodule

bind ep_irq_ctrl ep_irq_chk #(.ADDR_W(ADDR_W), .NF(ep_irq_pkg::NFLAG), .IRQ_REG(IRQ_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .ep_isoch  (ep_isoch),
   .stall_req (stall_req),
   .flags     (flags),
   .enables   (enables),
   .ep_irq    (ep_irq),
   .qual_set  (qual_set)
);

// File: tb/sim_ep_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ep_irq_ctrl;
   localparam int NF = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [NF-1:0] wr_data = '0;
   logic [NF-1:0] ev_pulse = '0;
   logic          ep_dir_in = 1'b0;
   logic          ep_isoch = 1'b0;
   logic          cfg_dmaend_en = 1'b0;
   logic          cfg_autosw = 1'b0;
   logic [NF-1:0] flags, enables;
   logic          stall_req, ep_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ep_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ev_pulse(ev_pulse), .ep_dir_in(ep_dir_in), .ep_isoch(ep_isoch),
      .cfg_dmaend_en(cfg_dmaend_en), .cfg_autosw(cfg_autosw),
      .flags(flags), .enables(enables), .stall_req(stall_req), .ep_irq(ep_irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [NF-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse(logic [NF-1:0] v);
      @(negedge clk);
      ev_pulse = v;
      @(negedge clk);
      ev_pulse = '0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 flags", 32'(flags), 0);
      check("R1 enables", 32'(enables), 0);
      check("R1 stall_req", 32'(stall_req), 0);
      check("R1 irq", 32'(ep_irq), 0);
   endtask

   task automatic t_raw_bits();
      do_reset();
      ep_isoch = 1'b1; ep_dir_in = 1'b1;
      pulse(9'b0_0011_1000);
      check("R2 raw overflow/nak bits", 32'(flags), 32'h038);
      @(negedge clk);
      check("R2 hold", 32'(flags), 32'h038);
      pulse(9'b1_1100_0100);
      check("R2 R8 R9 iso bits", 32'(flags), 32'h1FC);
   endtask

   task automatic t_clear();
      do_reset();
      ep_isoch = 1'b1; ep_dir_in = 1'b1;
      pulse(9'b1_1111_1100);
      wr(0, 9'b0);
      check("R3 zero write no effect", 32'(flags), 32'h1FC);
      wr(0, 9'b0_1010_0100);
      check("R3 partial clear", 32'(flags), 32'h158);
      wr(0, 9'h1FF);
      check("R3 clear all", 32'(flags), 0);
   endtask

   task automatic t_mask();
      do_reset();
      pulse(9'b0_0001_0000);
      check("R4 masked irq low", 32'(ep_irq), 0);
      wr(1, 9'b0_0010_0000);
      check("R4 enables loaded", 32'(enables), 32'h020);
      check("R4 other bit enabled irq low", 32'(ep_irq), 0);
      wr(1, 9'b0_0001_0000);
      check("R4 irq high", 32'(ep_irq), 1);
      wr(0, 9'b0_0001_0000);
      check("R4 irq drops after clear", 32'(ep_irq), 0);
   endtask

   task automatic t_short();
      do_reset();
      ep_dir_in = 1'b0;
      pulse(9'b1);
      check("R5 OUT short raw", 32'(flags[0]), 1);
      wr(0, 9'b1);
      ep_dir_in = 1'b1; cfg_dmaend_en = 1'b1; cfg_autosw = 1'b0;
      pulse(9'b1);
      check("R5 IN short blocked w/o autosw", 32'(flags[0]), 0);
      cfg_dmaend_en = 1'b0; cfg_autosw = 1'b1;
      pulse(9'b1);
      check("R5 IN short blocked w/o dmaend", 32'(flags[0]), 0);
      cfg_dmaend_en = 1'b1;
      pulse(9'b1);
      check("R5 IN short qualified", 32'(flags[0]), 1);
      cfg_dmaend_en = 1'b0; cfg_autosw = 1'b0;
   endtask

   task automatic t_stall();
      do_reset();
      pulse(9'b10);
      check("R6 stall sent blocked", 32'(flags[1]), 0);
      wr(2, 9'b0);
      check("R7 set with bit0=0 ignored", 32'(stall_req), 0);
      wr(2, 9'b1);
      check("R7 stall_req set", 32'(stall_req), 1);
      pulse(9'b10);
      check("R6 stall sent qualified", 32'(flags[1]), 1);
      wr(3, 9'b0);
      check("R7 clear with bit0=0 ignored", 32'(stall_req), 1);
      wr(3, 9'b1);
      check("R7 stall_req cleared", 32'(stall_req), 0);
   endtask

   task automatic t_gates();
      do_reset();
      ep_isoch = 1'b0; ep_dir_in = 1'b1;
      pulse(9'b1_1100_0100);
      check("R8 R9 non-iso blocked", 32'(flags), 0);
      ep_isoch = 1'b1; ep_dir_in = 1'b0;
      pulse(9'b1_1100_0100);
      check("R9 OUT blocks hb, R8 iso passes", 32'(flags), 32'h104);
   endtask

   task automatic t_race();
      do_reset();
      pulse(9'b0_0000_1000);
      @(negedge clk);
      ev_pulse = 9'b0_0010_0000;
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 9'b0_0010_1000;
      @(negedge clk);
      ev_pulse = '0; wr_en = 1'b0; wr_data = '0;
      check("R10 set beats clear", 32'(flags), 32'h020);
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_raw_bits();
      t_clear();
      t_mask();
      t_short();
      t_stall();
      t_gates();
      t_race();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule